// File: doc/BRIEF.md
# Prioritized Interrupt Vector Generator

This block keeps the interrupt flags of a serial transmit/receive peripheral, one flag per source, together with a per-source enable. It combines the enabled pending flags into a single registered interrupt request. It also presents a word-wide vector code that names the most urgent source that is both pending and enabled. Source 0 is receive-data-ready and has the higher priority. Source 1 is transmit-buffer-empty.

The serial engine reports hardware events on per-source set and clear strobes. A set strobe means a character was loaded into the receive buffer, or a buffered character moved into the transmit shift register. A clear strobe means the receive buffer was read, or the transmit buffer was written. The bus decoder supplies three things: write strobes for the flag and enable registers, the software-reset level, and a one-cycle strobe for every read or write access to the vector register. Such an access acknowledges the source the vector shows and clears only that source's flag. Interrupt service therefore reduces to reading the vector and jumping on its value. All pins are plain control and status levels or strobes. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure.

Top module: `irq_vec_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `flags` reads 2'b10 (bit 1 transmit-empty set, bit 0 receive-ready clear), `enables` reads 2'b00, `vector` reads 16'h0000 and `irq` reads 0.
- R2: `vector` is 16'h0002 when the receive source (bit 0) is pending and enabled, regardless of the transmit source. It is 16'h0004 when only the transmit source (bit 1) is pending and enabled. It is 16'h0000 when no source is both pending and enabled.
- R3: A source whose enable bit is 0 never contributes to `vector`, even while its flag is set.
- R4: A `vec_access` strobe clears, at the next edge, only the flag of the source that `vector` shows in that cycle. Other flags are kept. When `vector` is 16'h0000 the strobe changes nothing.
- R5: `src_set[1]` sets the transmit-empty flag and `src_clr[1]` clears it, each at the next clock edge.
- R6: `src_set[0]` sets the receive-ready flag and `src_clr[0]` clears it, each at the next clock edge.
- R7: A set strobe for a source overrides, in the same cycle, its clear strobe, a `vec_access` acknowledge and a flag-register write of 0. No event is lost.
- R8: `irq` is registered. In each cycle it equals the OR over sources of (flag AND enable) as it stood in the previous cycle.
- R9: `soft_rst` high forces `flags` to 2'b10, `enables` to 2'b00 and `irq` to 0 at the next edge. It takes precedence over every other input, set strobes included.
- R10: `flag_wr_en` loads `flags` from `flag_wr_data`, except for sources whose set strobe is active. `en_wr_en` loads `enables` from `en_wr_data` (bit 0 receive, bit 1 transmit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Software-reset level from the control register |
| src_set | input | 2 | Per-source hardware set strobes (bit 0 receive, bit 1 transmit) |
| src_clr | input | 2 | Per-source hardware clear strobes (buffer read / buffer write) |
| flag_wr_en | input | 1 | Flag register write strobe |
| flag_wr_data | input | 2 | Flag register write data |
| en_wr_en | input | 1 | Enable register write strobe |
| en_wr_data | input | 2 | Enable register write data |
| vec_access | input | 1 | One-cycle strobe for any access to the vector register |
| flags | output | 2 | Current interrupt flags |
| enables | output | 2 | Current interrupt enables |
| vector | output | 16 | Vector code of the highest-priority enabled pending source |
| irq | output | 1 | Registered combined interrupt request |

## Verification
The assertions check, on every cycle, that the vector is zero exactly when no enabled source is pending, and that a masked receive source never shows up in it. They also check that an acknowledge clears the receive flag without touching the transmit flag, that a set strobe always lands, that the request trails the pending state by one cycle, and that software reset restores the reset values. Only the bench scenarios can show the rest. Those behaviours are the full order of vector codes as acknowledges drain both sources, an acknowledge that has no effect when nothing is enabled, and the transmit source being masked while its flag stays set. They also include a flag-register write that loses to a simultaneous set, and the state after an asynchronous reset taken mid-stream.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int SRC_RX = 0;
  localparam int SRC_TX = 1;
  localparam int DEF_NUM_SRC = 2;
  localparam int DEF_VEC_W = 16;
  localparam int VEC_STEP = 2;
  // transmit-empty set out of reset, receive-ready clear
  localparam logic [DEF_NUM_SRC-1:0] DEF_FLAG_RST = 2'b10;

  function automatic int vec_code(input int idx);
    return VEC_STEP * (idx + 1);
  endfunction
endpackage

// File: rtl/irq_flag_cell.sv
module irq_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic set_evt,
  input  logic clr_evt,
  input  logic ack,
  input  logic wr_en,
  input  logic wr_val,
  output logic flag
);
  logic flag_nxt;

  always_comb begin
    flag_nxt = flag;
    if (soft_rst)              flag_nxt = RST_VAL;
    else if (set_evt)          flag_nxt = 1'b1;   // set never lost
    else if (wr_en)            flag_nxt = wr_val;
    else if (clr_evt || ack)   flag_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= RST_VAL;
    else        flag <= flag_nxt;
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NUM_SRC = 2,
  parameter int VEC_W   = 16
) (
  input  logic [NUM_SRC-1:0] pend,
  output logic [NUM_SRC-1:0] grant,
  output logic [VEC_W-1:0]   vec
);
  import irq_vec_pkg::*;

  // lowest index wins: scan from the top so it is assigned last
  always_comb begin
    grant = '0;
    vec   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        vec      = VEC_W'(vec_code(i));
      end
    end
  end
endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen
  import irq_vec_pkg::*;
#(
  parameter int                 NUM_SRC  = DEF_NUM_SRC,
  parameter int                 VEC_W    = DEF_VEC_W,
  parameter logic [NUM_SRC-1:0] FLAG_RST = DEF_FLAG_RST
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic [NUM_SRC-1:0] src_set,
  input  logic [NUM_SRC-1:0] src_clr,
  input  logic               flag_wr_en,
  input  logic [NUM_SRC-1:0] flag_wr_data,
  input  logic               en_wr_en,
  input  logic [NUM_SRC-1:0] en_wr_data,
  input  logic               vec_access,
  output logic [NUM_SRC-1:0] flags,
  output logic [NUM_SRC-1:0] enables,
  output logic [VEC_W-1:0]   vector,
  output logic               irq
);
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] grant;
  logic [NUM_SRC-1:0] ack;

  assign pend = flags & enables;
  assign ack  = grant & {NUM_SRC{vec_access}};

  irq_prio_enc #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_enc (
    .pend (pend),
    .grant(grant),
    .vec  (vector)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    irq_flag_cell #(.RST_VAL(FLAG_RST[g])) u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .soft_rst(soft_rst),
      .set_evt (src_set[g]),
      .clr_evt (src_clr[g]),
      .ack     (ack[g]),
      .wr_en   (flag_wr_en),
      .wr_val  (flag_wr_data[g]),
      .flag    (flags[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        enables <= '0;
    else if (soft_rst) enables <= '0;
    else if (en_wr_en) enables <= en_wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        irq <= 1'b0;
    else if (soft_rst) irq <= 1'b0;
    else               irq <= |pend;
  end
endmodule

// File: rtl/irq_vec_gen_chk.sv
module irq_vec_gen_chk #(
  parameter int                 NUM_SRC  = 2,
  parameter int                 VEC_W    = 16,
  parameter logic [NUM_SRC-1:0] FLAG_RST = 2'b10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               soft_rst,
  input logic [NUM_SRC-1:0] src_set,
  input logic [NUM_SRC-1:0] src_clr,
  input logic               flag_wr_en,
  input logic               vec_access,
  input logic [NUM_SRC-1:0] flags,
  input logic [NUM_SRC-1:0] enables,
  input logic [VEC_W-1:0]   vector,
  input logic               irq
);
  // R2
  vec_zero_iff_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vector == '0) == ((flags & enables) == '0));

  // R3
  rx_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enables[0] |-> (vector != VEC_W'(2)));

  // R4
  ack_clears_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_access && vector == VEC_W'(2) && !src_set[0] && !soft_rst) |=> !flags[0]);

  // R4
  ack_spares_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_access && vector == VEC_W'(2) && flags[1] && !src_clr[1] && !flag_wr_en && !soft_rst)
    |=> flags[1]);

  // R7
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_set[0] && !soft_rst) |=> flags[0]);

  // R8
  irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> (irq == $past(|(flags & enables))));

  // R9
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (flags == FLAG_RST && enables == '0 && !irq));
endmodule

bind irq_vec_gen irq_vec_gen_chk #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .FLAG_RST(FLAG_RST)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .soft_rst  (soft_rst),
  .src_set   (src_set),
  .src_clr   (src_clr),
  .flag_wr_en(flag_wr_en),
  .vec_access(vec_access),
  .flags     (flags),
  .enables   (enables),
  .vector    (vector),
  .irq       (irq)
);

// File: tb/irq_vec_gen_test.sv
module irq_vec_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic [1:0] src_set = '0;
  logic [1:0] src_clr = '0;
  logic       flag_wr_en = 1'b0;
  logic [1:0] flag_wr_data = '0;
  logic       en_wr_en = 1'b0;
  logic [1:0] en_wr_data = '0;
  logic       vec_access = 1'b0;
  logic [1:0] flags;
  logic [1:0] enables;
  logic [15:0] vector;
  logic       irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  irq_vec_gen uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .src_set(src_set), .src_clr(src_clr),
    .flag_wr_en(flag_wr_en), .flag_wr_data(flag_wr_data),
    .en_wr_en(en_wr_en), .en_wr_data(en_wr_data),
    .vec_access(vec_access),
    .flags(flags), .enables(enables), .vector(vector), .irq(irq)
  );

  // stimulus [20:9]: soft_rst, set0, clr0, set1, clr1, fwe, fwd[1:0], ewe, ewd[1:0], access
  // expected [8:0] : flags[1:0], enables[1:0], vector low nibble, irq
  localparam int NROW = 19;
  localparam logic [20:0] TBL [NROW] = '{
    {12'b0_0_0_0_0_0_00_1_11_0, 2'b10, 2'b11, 4'h4, 1'b0},
    {12'b0_0_0_0_0_0_00_0_00_0, 2'b10, 2'b11, 4'h4, 1'b1},
    {12'b0_1_0_0_0_0_00_0_00_0, 2'b11, 2'b11, 4'h2, 1'b1},
    {12'b0_0_0_0_0_0_00_0_00_1, 2'b10, 2'b11, 4'h4, 1'b1},
    {12'b0_0_0_0_0_0_00_0_00_1, 2'b00, 2'b11, 4'h0, 1'b1},
    {12'b0_0_0_0_0_0_00_0_00_0, 2'b00, 2'b11, 4'h0, 1'b0},
    {12'b0_0_0_1_0_0_00_0_00_0, 2'b10, 2'b11, 4'h4, 1'b0},
    {12'b0_0_0_0_1_0_00_0_00_0, 2'b00, 2'b11, 4'h0, 1'b1},
    {12'b0_0_0_0_0_0_00_1_01_0, 2'b00, 2'b01, 4'h0, 1'b0},
    {12'b0_0_0_1_0_0_00_0_00_0, 2'b10, 2'b01, 4'h0, 1'b0},
    {12'b0_1_0_0_0_0_00_0_00_1, 2'b11, 2'b01, 4'h2, 1'b0},
    {12'b0_1_0_0_0_0_00_0_00_1, 2'b11, 2'b01, 4'h2, 1'b1},
    {12'b0_0_1_0_0_0_00_0_00_0, 2'b10, 2'b01, 4'h0, 1'b1},
    {12'b0_0_0_0_0_1_01_0_00_0, 2'b01, 2'b01, 4'h2, 1'b0},
    {12'b0_0_0_1_0_1_00_0_00_0, 2'b10, 2'b01, 4'h0, 1'b1},
    {12'b0_0_0_0_0_0_00_1_10_0, 2'b10, 2'b10, 4'h4, 1'b0},
    {12'b0_0_0_1_0_0_00_0_00_1, 2'b10, 2'b10, 4'h4, 1'b1},
    {12'b1_1_0_0_0_0_00_0_00_0, 2'b10, 2'b00, 4'h0, 1'b0},
    {12'b0_0_0_0_0_0_00_0_00_1, 2'b10, 2'b00, 4'h0, 1'b0}
  };
  localparam string TAG [NROW] = '{
    "R10", "R8", "R6", "R4", "R4", "R8", "R5", "R5", "R10", "R3",
    "R4", "R7", "R6", "R10", "R7", "R2", "R7", "R9", "R4"
  };

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input logic [1:0] ef, input logic [1:0] ee,
                         input logic [15:0] ev, input logic ei);
    chk(tag, "flags", {14'b0, flags}, {14'b0, ef});
    chk(tag, "enables", {14'b0, enables}, {14'b0, ee});
    chk(tag, "vector", vector, ev);
    chk(tag, "irq", {15'b0, irq}, {15'b0, ei});
  endtask

  task automatic drive(input logic [11:0] s);
    soft_rst     = s[11];
    src_set[0]   = s[10];
    src_clr[0]   = s[9];
    src_set[1]   = s[8];
    src_clr[1]   = s[7];
    flag_wr_en   = s[6];
    flag_wr_data = s[5:4];
    en_wr_en     = s[3];
    en_wr_data   = s[2:1];
    vec_access   = s[0];
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 state held in reset
    chk_all("R1", 2'b10, 2'b00, 16'h0000, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1", 2'b10, 2'b00, 16'h0000, 1'b0);

    for (int r = 0; r < NROW; r++) begin
      drive(TBL[r][20:9]);
      @(negedge clk);
      chk_all(TAG[r], TBL[r][8:7], TBL[r][6:5], {12'b0, TBL[r][4:1]}, TBL[r][0]);
    end
    drive('0);
    @(negedge clk);

    // R2 both pending and enabled: receive wins
    drive(12'b0_1_0_1_0_0_00_1_11_0);
    @(negedge clk);
    drive('0);
    chk("R2", "vector both", vector, 16'h0002);
    @(negedge clk);
    chk("R8", "irq both", {15'b0, irq}, 16'h0001);

    // R1 asynchronous reset mid-stream
    rst_n = 1'b0;
    #1;
    chk_all("R1", 2'b10, 2'b00, 16'h0000, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1", 2'b10, 2'b00, 16'h0000, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule